// File: doc/BRIEF.md
# Keyed Watchdog Timer with Halt-Mode Register

This block is a watchdog timer that counts cycles of a prescaled time base, with `tick` high once per time-base step. If software does not service it in time, it raises a one-clock reset request. Software talks to it through one byte-wide write port. A select line picks either the configuration register or the command register. The configuration register holds the enable, the timeout choice and a two-bit halt/power-down mode code. The command register reacts only to three key bytes.

Two safeguards keep runaway code from stopping the watchdog by accident. A configuration write counts only when its low three bits carry a fixed tag. Stopping the timer takes two steps: first clear the stored enable bit, then write the stop key. The halt mode code changes only when the most recent command write was the halt key. The block leaves reset running at its longest timeout, so boot code has to stop it or service it on purpose. The halt mode code is an output for the power-management logic elsewhere in the chip.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer runs with the longest timeout (2^(BASE_EXP+3*STEP_EXP) ticks), `halt_mode` is 3 (run) and `rst_req` is low.
- R2: A configuration write (`wr_sel`=0) whose bits 2:0 are not 3'b011 changes nothing: not enable, timeout, halt mode, nor a pending halt key.
- R3: Configuration bits 6:5 pick a timeout of 2^(BASE_EXP+STEP_EXP*k) ticks for k=0..3. On the tick that makes that many ticks since the counter was last zero, `rst_req` is high for exactly the next clock and the count restarts at zero.
- R4: A valid configuration write with bit 7 = 0 only stores a cleared enable, and the timer keeps running. A later command byte 0xB1 stops it and holds the count at zero. 0xB1 while the stored enable is 1 has no effect.
- R5: A valid configuration write with bit 7 = 1 starts a stopped timer, counting from zero.
- R6: Command byte 0x4E clears the count to zero. It wins over a tick in the same cycle, which then neither counts nor expires.
- R7: `halt_mode` takes bits 4:3 of a valid configuration write (0 idle 1, 1 idle 2, 2 stop, 3 run) only if the last command write was 0xDB. Any other command byte cancels that key, and a valid configuration write uses it up.
- R8: Command bytes other than 0xB1, 0x4E and 0xDB have no effect on the count or on whether the timer runs.
- R9: A timeout change takes effect at once. If the count already reaches the new limit, the next tick expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_sel | input | 1 | 0 = configuration register, 1 = command register |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Time-base step enable |
| rst_req | output | 1 | One-clock reset request on expiry |
| halt_mode | output | 2 | Halt/power-down mode code |

## Verification
The bench covers the cases that separate a real two-step stop from a plain enable bit. It clears the enable without the stop key and expects expiry anyway, and it sends the stop key while the enable is still set. A design with a weaker guard would go quiet in one of these cases. The bench also sends an invalid configuration write between the halt key and a valid write, which catches a design that lets the bad write use up or cancel the key. Other directed cases are a clear landing in the same cycle as the expiring tick, a shorter timeout chosen while the count is already past it, and junk command bytes that must not service the counter. Each of these shows up as a reset pulse that is early, late or missing.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
    localparam logic [7:0] KEY_STOP  = 8'hB1;
    localparam logic [7:0] KEY_CLEAR = 8'h4E;
    localparam logic [7:0] KEY_HALT  = 8'hDB;
    localparam logic [2:0] CFG_TAG   = 3'b011;

    typedef enum logic [1:0] {
        HM_IDLE1 = 2'd0,
        HM_IDLE2 = 2'd1,
        HM_STOP  = 2'd2,
        HM_RUN   = 2'd3
    } halt_e;

    typedef struct packed {
        logic       cfg_en;
        logic       active;
        logic [1:0] psel;
        halt_e      halt;
        logic       key;
    } ctrl_t;
endpackage

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
    import keyed_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       active,
    output logic       clr,
    output logic [1:0] psel,
    output logic [1:0] halt_mode
);
    ctrl_t ctl_d, ctl_q;
    logic  cfg_ok, cmd_wr;

    always_comb begin
        ctl_d  = ctl_q;
        cfg_ok = wr_en && !wr_sel && (wr_data[2:0] == CFG_TAG);
        cmd_wr = wr_en && wr_sel;
        clr    = cmd_wr && (wr_data == KEY_CLEAR);
        if (cfg_ok) begin
            ctl_d.cfg_en = wr_data[7];
            ctl_d.psel   = wr_data[6:5];
            if (wr_data[7]) ctl_d.active = 1'b1;
            if (ctl_q.key)  ctl_d.halt   = halt_e'(wr_data[4:3]);
            ctl_d.key = 1'b0;
        end
        if (cmd_wr) begin
            ctl_d.key = (wr_data == KEY_HALT);
            if (wr_data == KEY_STOP && !ctl_q.cfg_en) ctl_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.cfg_en <= 1'b1;
            ctl_q.active <= 1'b1;
            ctl_q.psel   <= 2'd3;
            ctl_q.halt   <= HM_RUN;
            ctl_q.key    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active    = ctl_q.active;
    assign psel      = ctl_q.psel;
    assign halt_mode = ctl_q.halt;

    // R2
    bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[2:0] != CFG_TAG) |=>
            ($stable(ctl_q.cfg_en) && $stable(ctl_q.psel) && $stable(ctl_q.halt) && $stable(ctl_q.key)));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_sel && wr_data[2:0] == CFG_TAG) |=> $stable(halt_mode));

    // R8
    junk_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data != KEY_STOP) |=> $stable(active));
endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter #(
    parameter int BASE_EXP = 16,
    parameter int STEP_EXP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] psel,
    output logic       rst_req
);
    localparam int CW = BASE_EXP + 3 * STEP_EXP;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } cnt_t;

    cnt_t          cs_d, cs_q;
    logic [CW-1:0] lim;
    int            shamt;

    always_comb begin
        shamt = BASE_EXP + STEP_EXP * int'(psel);
        lim   = (CW'(1) << shamt) - CW'(1);
        cs_d  = cs_q;
        cs_d.pulse = 1'b0;
        if (!active || clr) begin
            cs_d.cnt = '0;
        end else if (tick) begin
            if (cs_q.cnt >= lim) begin
                cs_d.cnt   = '0;
                cs_d.pulse = 1'b1;
            end else begin
                cs_d.cnt = cs_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign rst_req = cs_q.pulse;

    // R3
    pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cs_q.cnt == '0 && !rst_req));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cs_q.cnt == '0 && !rst_req));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int BASE_EXP = 16,
    parameter int STEP_EXP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       tick,
    output logic       rst_req,
    output logic [1:0] halt_mode
);
    logic       active, clr;
    logic [1:0] psel;

    keyed_wdt_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .active(active), .clr(clr), .psel(psel), .halt_mode(halt_mode)
    );

    keyed_wdt_counter #(.BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP)) i_counter (
        .clk(clk), .rst_n(rst_n), .active(active), .clr(clr), .tick(tick),
        .psel(psel), .rst_req(rst_req)
    );

    // R4
    req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(active) && $past(tick)));
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
    localparam int BE = 4;
    localparam int SE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, tick = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rst_req;
    logic [1:0] halt_mode;

    int checks = 0, fails = 0, cycles = 0;

    bit         m_cfgen, m_active, m_key, m_pulse;
    logic [1:0] m_sel, m_halt;
    int         m_cnt;

    keyed_wdt #(.BASE_EXP(BE), .STEP_EXP(SE)) i_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick(tick), .rst_req(rst_req), .halt_mode(halt_mode)
    );

    always #5 clk = ~clk;

    function automatic int period_of(input logic [1:0] k);
        return 1 << (BE + SE * int'(k));
    endfunction

    // reference model from the requirements
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cfgen = 1; m_active = 1; m_key = 0; m_pulse = 0;
            m_sel = 2'd3; m_halt = 2'd3; m_cnt = 0;
        end else begin
            automatic bit ok  = wr_en && !wr_sel && wr_data[2:0] == 3'b011;
            automatic bit cmd = wr_en && wr_sel;
            m_pulse = 0;
            if (!m_active || (cmd && wr_data == 8'h4E)) m_cnt = 0;
            else if (tick) begin
                if (m_cnt + 1 >= period_of(m_sel)) begin m_cnt = 0; m_pulse = 1; end
                else m_cnt++;
            end
            if (ok) begin
                m_cfgen = wr_data[7];
                m_sel = wr_data[6:5];
                if (wr_data[7]) m_active = 1;
                if (m_key) m_halt = wr_data[4:3];
                m_key = 0;
            end
            if (cmd) begin
                m_key = (wr_data == 8'hDB);
                if (wr_data == 8'hB1 && !m_cfgen) m_active = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic s, input logic [7:0] d, input logic t);
        wr_en = e; wr_sel = s; wr_data = d; tick = t;
        @(posedge clk);
        #2;
        wr_en = 0; tick = 0;
        chk("R3 model pulse", {7'd0, rst_req}, {7'd0, m_pulse});
        chk("R7 model halt", {6'd0, halt_mode}, {6'd0, m_halt});
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        step(1'b1, s, d, 1'b0);
    endtask

    task automatic tick_n(input int n, input int exp_at, input string tag);
        for (int i = 1; i <= n; i++) begin
            step(1'b0, 1'b0, 8'h00, 1'b1);
            if (i == exp_at || rst_req) chk(tag, {7'd0, rst_req}, {7'd0, i == exp_at});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        chk("R1 halt after reset", {6'd0, halt_mode}, 8'd3);
        chk("R1 req after reset", {7'd0, rst_req}, 8'd0);
        tick_n(1024, 1024, "R1 longest timeout");

        wr(1, 8'hDB); wr(0, 8'h00);
        chk("R2 bad cfg ignored", {6'd0, halt_mode}, 8'd3);
        wr(0, 8'h93);
        chk("R2 key survives bad cfg", {6'd0, halt_mode}, 8'd2);
        wr(1, 8'h4E);
        tick_n(16, 16, "R3 shortest timeout");

        wr(0, 8'h8B);
        chk("R7 no key", {6'd0, halt_mode}, 8'd2);
        wr(1, 8'hDB); wr(1, 8'h4E); wr(0, 8'h83);
        chk("R7 key cancelled", {6'd0, halt_mode}, 8'd2);
        wr(1, 8'hDB); wr(0, 8'h9B);
        chk("R7 keyed change", {6'd0, halt_mode}, 8'd3);

        wr(0, 8'h03); wr(1, 8'h4E);
        tick_n(16, 16, "R4 enable cleared still runs");
        wr(1, 8'hB1);
        tick_n(1500, 0, "R4 stopped");
        wr(1, 8'h12); wr(1, 8'h4E);
        tick_n(100, 0, "R8 junk does not start");

        wr(0, 8'h83);
        tick_n(10, 0, "R5 restart from zero");
        wr(1, 8'h55);
        tick_n(6, 6, "R8 junk does not clear");

        wr(1, 8'hB1);
        tick_n(16, 16, "R4 stop key with enable set");

        wr(0, 8'hE3); wr(1, 8'h4E);
        tick_n(100, 0, "R9 long period");
        wr(0, 8'h83);
        tick_n(1, 1, "R9 shorter period expires");

        tick_n(15, 0, "R6 prefill");
        step(1'b1, 1'b1, 8'h4E, 1'b1);
        chk("R6 clear beats tick", {7'd0, rst_req}, 8'd0);
        tick_n(16, 16, "R6 full period after clear");

        for (int i = 0; i < 6000; i++) begin
            automatic int r = int'($urandom % 16);
            automatic logic [7:0] d = 8'($urandom);
            automatic logic s = 1'($urandom);
            automatic logic t = 1'($urandom);
            if (r == 0) begin
                case ($urandom % 4)
                    0: d = 8'hB1;
                    1: d = 8'h4E;
                    2: d = 8'hDB;
                    default: ;
                endcase
                if (!s && ($urandom % 4 != 0)) d[2:0] = 3'b011;
                if (!s && ($urandom % 2 == 0)) d[6:5] = 2'b00;
                step(1'b1, s, d, t);
            end else begin
                step(1'b0, 1'b0, 8'h00, t);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule